// File: doc/BRIEF.md
# Serial Bit Clock Tick Generator

This block turns the system clock into a stream of single-cycle enable ticks for a serial shift engine. A tick marks each half of a serial bit period, so the shift engine can place both the launching and the sampling edge of its serial clock from the same strobe. No clock net is generated. The tick period comes from two dividers in cascade: an even prescaler and an eight-bit rate divider. The serial bit rate is therefore the system clock divided by PRE × (1 + RATE).

Software loads both divisors through simple write strobes and can read back the values the block keeps. The prescaler keeps only even values, and anything smaller than two is raised to two. The ticks run only while the port is enabled and a transfer is in progress. In every other cycle the tick is silent, so the serial clock stays at its idle level. A divisor write, a disabled port or an idle transfer puts both counters back at the start of a period. A restart therefore always begins with a full half period.

Top module: `spiclk_gen`

## Requirements
- R1: After reset the stored prescaler reads 2, the stored rate divider reads 0, and `halfTick` is low.
- R2: While running, consecutive ticks are exactly (PRE/2) × (RATE+1) cycles apart. PRE is the stored prescaler and RATE the stored rate divider.
- R3: When `xferActive` rises with the port enabled, counting starts after one reload cycle. Taking that reload cycle as cycle 0, the first tick comes in cycle (PRE/2) × (RATE+1).
- R4: Bit 0 of a prescaler write is dropped: the stored value, and so the divisor in use, is the written value with bit 0 cleared.
- R5: A prescaler write whose value with bit 0 cleared is below 2 stores 2.
- R6: The rate divider accepts every value from 0 to 255 and reads back unchanged.
- R7: A write to either divisor while running starts a fresh period with the new values. The tick is low in the write cycle and in the cycle after it, and the first new tick arrives (PRE/2) × (RATE+1) cycles after that reload cycle.
- R8: When (PRE/2) × (RATE+1) is above 1, every tick lasts exactly one cycle.
- R9: `halfTick` is low in every cycle in which `portEnable` or `xferActive` is low. Re-enabling after such a pause restarts a full period as in R3.
- R10: At the fastest setting (PRE 2, RATE 0) a tick is produced every cycle. At the slowest setting (PRE 254, RATE 255) ticks are 32512 cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| portEnable | input | 1 | Port enable; low holds the dividers in reload |
| xferActive | input | 1 | High while a transfer is in progress |
| preWrEn | input | 1 | Write strobe for the prescaler |
| preWrData | input | 8 | Prescaler write value |
| scrWrEn | input | 1 | Write strobe for the rate divider |
| scrWrData | input | 8 | Rate divider write value |
| preRd | output | 8 | Stored prescaler value |
| scrRd | output | 8 | Stored rate divider value |
| halfTick | output | 1 | One-cycle tick per half serial bit period |

## Verification
The bench aims at the two divisor extremes. A counter that was off by one, or that treated a zero rate divider as 256, would show a wrong gap at PRE 2/RATE 0 or at the 32512-cycle slowest setting. Odd and sub-minimum prescaler writes are read back and timed, which catches a design that keeps bit 0 or lets a zero divisor stall the counter. A divisor write in the middle of a period, and enable or transfer dropping out, are used to find stale counts that would shorten the next period, or ticks that leak while the port is idle.

// File: rtl/spiclk_pkg.sv
package spiclk_pkg;
  // Strobes from the control half to the divider datapath
  typedef struct packed {
    logic reload;  // load both counters with the start-of-period values
    logic run;     // advance the counters this cycle
  } clkStrobeT;
endpackage

// File: rtl/spiclk_ctl.sv
module spiclk_ctl
  import spiclk_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int SCR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEnable,
  input  logic             xferActive,
  input  logic             preWrEn,
  input  logic [PRE_W-1:0] preWrData,
  input  logic             scrWrEn,
  input  logic [SCR_W-1:0] scrWrData,
  output logic [PRE_W-1:0] preReg,
  output logic [SCR_W-1:0] scrReg,
  output clkStrobeT        strobes
);
  localparam logic [PRE_W-1:0] PRE_MIN = PRE_W'(2);

  logic             wrAny;
  logic             reloadQ;
  logic [PRE_W-1:0] preEven;
  logic [PRE_W-1:0] preNext;

  assign wrAny   = preWrEn | scrWrEn;
  assign preEven = {preWrData[PRE_W-1:1], 1'b0};
  assign preNext = (preEven < PRE_MIN) ? PRE_MIN : preEven;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      preReg  <= PRE_MIN;
      scrReg  <= '0;
      reloadQ <= 1'b1;
    end else begin
      if (preWrEn) preReg <= preNext;
      if (scrWrEn) scrReg <= scrWrData;
      // a write or a stop puts the dividers back at period start next cycle
      reloadQ <= wrAny | ~portEnable | ~xferActive;
    end
  end

  always_comb begin
    strobes.reload = reloadQ;
    strobes.run    = portEnable & xferActive & ~reloadQ & ~wrAny;
  end

  // R4: the stored prescaler is always even
  p_prescale_even_r4: assert property (@(posedge clk) disable iff (!rstN)
    preReg[0] == 1'b0);

  // R5: the stored prescaler never falls below two
  p_prescale_min_r5: assert property (@(posedge clk) disable iff (!rstN)
    preReg >= PRE_MIN);

  // R7: the cycle after a divisor write is a reload cycle, never a run cycle
  p_write_reload_r7: assert property (@(posedge clk) disable iff (!rstN)
    wrAny |=> (strobes.reload && !strobes.run));
endmodule

// File: rtl/spiclk_dp.sv
module spiclk_dp
  import spiclk_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int SCR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  clkStrobeT        strobes,
  input  logic [PRE_W-2:0] preHalf,
  input  logic [SCR_W-1:0] scrVal,
  output logic             halfTick
);
  localparam int HALF_W = PRE_W - 1;

  logic [HALF_W-1:0] preCnt;
  logic [SCR_W-1:0]  scrCnt;
  logic [HALF_W-1:0] preLoad;
  logic              preTick;

  assign preLoad  = preHalf - HALF_W'(1);
  assign preTick  = strobes.run && (preCnt == '0);
  assign halfTick = preTick && (scrCnt == '0);

  // first stage: divide by half the even prescaler
  always_ff @(posedge clk) begin
    if (!rstN) begin
      preCnt <= '0;
    end else if (strobes.reload) begin
      preCnt <= preLoad;
    end else if (strobes.run) begin
      preCnt <= (preCnt == '0) ? preLoad : preCnt - HALF_W'(1);
    end
  end

  // second stage: count RATE+1 prescaler ticks per half bit
  always_ff @(posedge clk) begin
    if (!rstN) begin
      scrCnt <= '0;
    end else if (strobes.reload) begin
      scrCnt <= scrVal;
    end else if (preTick) begin
      scrCnt <= (scrCnt == '0) ? scrVal : scrCnt - SCR_W'(1);
    end
  end

  // R2: while running, the counters stay inside the current divisor range
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.run |-> (preCnt < preHalf && scrCnt <= scrVal));

  // R8: a tick is followed by a quiet cycle unless the period is one cycle
  p_single_tick_r8: assert property (@(posedge clk) disable iff (!rstN)
    (halfTick && !(preHalf == HALF_W'(1) && scrVal == '0)) |=> !halfTick);
endmodule

// File: rtl/spiclk_gen.sv
module spiclk_gen
  import spiclk_pkg::*;
#(
  parameter int PRE_W = 8,
  parameter int SCR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             portEnable,
  input  logic             xferActive,
  input  logic             preWrEn,
  input  logic [PRE_W-1:0] preWrData,
  input  logic             scrWrEn,
  input  logic [SCR_W-1:0] scrWrData,
  output logic [PRE_W-1:0] preRd,
  output logic [SCR_W-1:0] scrRd,
  output logic             halfTick
);
  clkStrobeT        strobes;
  logic [PRE_W-1:0] preReg;
  logic [SCR_W-1:0] scrReg;

  spiclk_ctl #(.PRE_W(PRE_W), .SCR_W(SCR_W)) i_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .portEnable (portEnable),
    .xferActive (xferActive),
    .preWrEn    (preWrEn),
    .preWrData  (preWrData),
    .scrWrEn    (scrWrEn),
    .scrWrData  (scrWrData),
    .preReg     (preReg),
    .scrReg     (scrReg),
    .strobes    (strobes)
  );

  spiclk_dp #(.PRE_W(PRE_W), .SCR_W(SCR_W)) i_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .preHalf  (preReg[PRE_W-1:1]),
    .scrVal   (scrReg),
    .halfTick (halfTick)
  );

  assign preRd = preReg;
  assign scrRd = scrReg;

  // R9: no tick without an enabled port and an active transfer
  p_tick_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    halfTick |-> (portEnable && xferActive));
endmodule

// File: tb/test_spiclk_gen.sv
module test_spiclk_gen;
  localparam int CLK_PERIOD = 10;
  localparam int MEAS_LIMIT = 40000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       portEnable = 1'b0;
  logic       xferActive = 1'b0;
  logic       preWrEn = 1'b0;
  logic [7:0] preWrData = '0;
  logic       scrWrEn = 1'b0;
  logic [7:0] scrWrData = '0;
  logic [7:0] preRd;
  logic [7:0] scrRd;
  logic       halfTick;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spiclk_gen i_spiclk_gen (
    .clk(clk), .rstN(rstN), .portEnable(portEnable), .xferActive(xferActive),
    .preWrEn(preWrEn), .preWrData(preWrData), .scrWrEn(scrWrEn),
    .scrWrData(scrWrData), .preRd(preRd), .scrRd(scrRd), .halfTick(halfTick)
  );

  task automatic check(input string req, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int halfPeriod(input int pre, input int scr);
    return (pre / 2) * (scr + 1);
  endfunction

  // Count samples up to and including the next tick; every routine starts and ends at a negedge
  task automatic measure(output int cnt);
    cnt = 0;
    for (int i = 0; i < MEAS_LIMIT; i++) begin
      @(posedge clk); @(negedge clk);
      cnt++;
      if (halfTick) return;
    end
  endtask

  task automatic writePre(input int v);
    preWrData = 8'(v); preWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    preWrEn = 1'b0;
  endtask

  task automatic writeScr(input int v);
    scrWrData = 8'(v); scrWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    scrWrEn = 1'b0;
  endtask

  task automatic idleCycles(input int n);
    for (int i = 0; i < n; i++) begin @(posedge clk); @(negedge clk); end
  endtask

  // Configure while idle, start a transfer, and time the first two ticks
  task automatic runCase(input string req, input int pre, input int scr, input int expPre);
    int c;
    int n;
    xferActive = 1'b0;
    writePre(pre);
    writeScr(scr);
    idleCycles(2);
    n = halfPeriod(expPre, scr);
    xferActive = 1'b1;
    measure(c);
    check({req, " first tick latency"}, c, n);
    measure(c);
    check({req, " tick interval"}, c, n);
    xferActive = 1'b0;
    idleCycles(2);
  endtask

  task automatic testReset();
    check("R1 prescaler reset value", preRd, 2);
    check("R1 rate divider reset value", scrRd, 0);
    check("R1 tick low after reset", halfTick, 0);
  endtask

  task automatic testFastest();
    int c;
    runCase("R10 fastest", 2, 0, 2);
    xferActive = 1'b1;
    measure(c);
    measure(c);
    check("R10 tick on consecutive cycle at fastest rate", c, 1);
    xferActive = 1'b0;
    idleCycles(2);
  endtask

  task automatic testOddPrescale();
    writePre(7);
    check("R4 odd prescaler reads back even", preRd, 6);
    runCase("R4 odd prescaler", 7, 0, 6);
  endtask

  task automatic testLowPrescale();
    writePre(0);
    check("R5 zero prescaler stored as 2", preRd, 2);
    writePre(1);
    check("R5 one prescaler stored as 2", preRd, 2);
    runCase("R5 sub-minimum prescaler", 1, 2, 2);
  endtask

  task automatic testMidRate();
    runCase("R2 R3 prescaler 10 rate 3", 10, 3, 10);
  endtask

  task automatic testRateFull();
    writeScr(255);
    check("R6 rate divider 255 readback", scrRd, 255);
    writeScr(0);
    check("R6 rate divider 0 readback", scrRd, 0);
    runCase("R6 rate 255", 4, 255, 4);
  endtask

  task automatic testSlowest();
    runCase("R10 slowest", 254, 255, 254);
  endtask

  task automatic testWriteRestart();
    int c;
    xferActive = 1'b0;
    writePre(10);
    writeScr(3);
    idleCycles(2);
    xferActive = 1'b1;
    idleCycles(7);
    scrWrData = 8'd1; scrWrEn = 1'b1;
    check("R7 tick low in write cycle", halfTick, 0);
    @(posedge clk); @(negedge clk);
    scrWrEn = 1'b0;
    check("R7 tick low in reload cycle", halfTick, 0);
    measure(c);
    check("R7 new period after write", c, halfPeriod(10, 1));
    xferActive = 1'b0;
    idleCycles(2);
  endtask

  task automatic testSingleTick();
    int c;
    xferActive = 1'b0;
    writePre(8);
    writeScr(0);
    idleCycles(2);
    xferActive = 1'b1;
    measure(c);
    @(posedge clk); @(negedge clk);
    check("R8 tick lasts one cycle", halfTick, 0);
    xferActive = 1'b0;
    idleCycles(2);
  endtask

  task automatic testGating();
    int c;
    int seen;
    xferActive = 1'b0;
    writePre(4);
    writeScr(4);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(posedge clk); @(negedge clk);
      seen += int'(halfTick);
    end
    check("R9 no tick while transfer idle", seen, 0);
    xferActive = 1'b1;
    idleCycles(5);
    portEnable = 1'b0;
    seen = 0;
    for (int i = 0; i < 30; i++) begin
      @(posedge clk); @(negedge clk);
      seen += int'(halfTick);
    end
    check("R9 no tick while port disabled", seen, 0);
    portEnable = 1'b1;
    measure(c);
    check("R9 full period after re-enable", c, halfPeriod(4, 4));
    xferActive = 1'b0;
    idleCycles(2);
  endtask

  initial begin
    #(CLK_PERIOD * 190000);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    idleCycles(3);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    portEnable = 1'b1;
    testFastest();
    testMidRate();
    testOddPrescale();
    testLowPrescale();
    testRateFull();
    testWriteRestart();
    testSingleTick();
    testGating();
    testSlowest();
    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end
endmodule